// File: doc/BRIEF.md
# RS485 Transceiver Direction Controller

This block drives the direction pin of a half-duplex RS485 transceiver that sits beside a UART transmitter. While the transmitter has queued data or is shifting a character out, the direction output is held high so that the line driver is on. When the FIFO is empty and the shift register has sent the last stop bit, the output stays high for a programmable turnaround time. The turnaround is a whole number of bit periods, taken from a 4-bit field. The output then falls so that the transceiver can listen for the reply.

The feature is switched on in one of two ways. A strap input is captured on the first clock after reset, or a software control bit is set at run time. While the feature is on, the block also tells the interrupt logic to use shift-register-empty as the transmit-empty source, so that software does not act before the line is released. The direction state can be routed to either the request-to-send pin or the data-terminal-ready pin. The pin that is not selected stays at its inactive low level.

Top module: `rs485_dir_ctl`

## Requirements
- R1: The feature is enabled when the strap value captured on the first clock edge after reset is 1, or when `swEn` is 1. Changes on `strapEn` after that edge have no effect. `txIntSel` is 1 (shift-register-empty source) while the feature is enabled, and 0 (FIFO-empty source) otherwise.
- R2: While the feature is enabled, the selected direction pin is high from the clock cycle after `txBusy` is 1 or `fifoEmpty` is 0.
- R3: When the feature is enabled, `txBusy` is 0 and `fifoEmpty` is 1, the direction pin stays high for exactly N×OVS `baudTick` pulses before it goes low, where N = `delayCfg`. Clock cycles without `baudTick` do not advance the count.
- R4: The turnaround count starts only when the last stop bit has ended (`txBusy` falls). An empty FIFO while `txBusy` is high keeps the pin high without limit.
- R5: With `delayCfg` = 0, the pin goes low on the first clock edge that sees the transmitter idle and the FIFO empty.
- R6: If `fifoEmpty` goes to 0 or `txBusy` goes to 1 during the turnaround, the count is abandoned and the pin stays high. The next idle period then counts the full delay again.
- R7: While the feature is disabled, both direction pins are low whatever the transmitter does.
- R8: `pinSel` = 0 routes the direction state to `rtsOut`, and `pinSel` = 1 routes it to `dtrOut`. The pin that is not selected is low. The two pins are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strapEn | input | 1 | Enable strap, captured on the first edge after reset |
| swEn | input | 1 | Software enable bit |
| pinSel | input | 1 | 0: output on rtsOut, 1: output on dtrOut |
| delayCfg | input | 4 | Turnaround delay in bit periods |
| baudTick | input | 1 | Oversampling baud tick, OVS ticks per bit |
| txBusy | input | 1 | Shift register is sending a character, stop bit included |
| fifoEmpty | input | 1 | Transmit FIFO holds no data |
| rtsOut | output | 1 | Direction output on the request-to-send pin |
| dtrOut | output | 1 | Direction output on the data-terminal-ready pin |
| txIntSel | output | 1 | 1: transmit interrupt from shift-register-empty |

## Verification
Several rules are checked by the assertions on every cycle: a busy transmitter raises the direction state on the next cycle, a disabled block is idle, a zero delay releases the line at once, new data during the turnaround returns the block to the active state, a running count never reaches zero, and the two pins are never high together. The exact length of the turnaround can only be shown by the bench scenarios. These sweep every delay value, both pins, both enable sources and a sparse tick, and count the cycles the pin stays high against N×OVS. The bench also shows that a count abandoned partway restarts in full, and that the strap is ignored after it has been captured.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE   = 2'd0,
    DIR_ACTIVE = 2'd1,
    DIR_HOLD   = 2'd2
  } dirState_e;

  typedef struct packed {
    logic load;
    logic run;
  } dlyCmd_t;
endpackage

// File: rtl/rs485_dir_delay.sv
module rs485_dir_delay
  import rs485_dir_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dlyCmd_t          cmd,
  input  logic             baudTick,
  input  logic [DLY_W-1:0] delayCfg,
  output logic             done
);
  localparam int TW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(OVS - 1);

  logic [TW-1:0]    tickCnt;
  logic [DLY_W-1:0] bitCnt;
  logic             bitEnd;

  assign bitEnd = cmd.run && baudTick && (tickCnt == TICK_LAST);
  assign done   = bitEnd && (bitCnt == DLY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (cmd.load) begin
      tickCnt <= '0;
      bitCnt  <= delayCfg;
    end else if (cmd.run && baudTick) begin
      if (bitEnd) begin
        tickCnt <= '0;
        bitCnt  <= bitCnt - DLY_W'(1);
      end else begin
        tickCnt <= tickCnt + TW'(1);
      end
    end
  end

  // R3
  run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.run |-> (bitCnt != '0));
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strapEn,
  input  logic             swEn,
  input  logic [DLY_W-1:0] delayCfg,
  input  logic             txBusy,
  input  logic             fifoEmpty,
  input  logic             done,
  output dlyCmd_t          cmd,
  output logic             dirOn,
  output logic             featEn
);
  dirState_e state, stateNxt;
  logic      strapQ, sampledQ, txReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strapQ   <= 1'b0;
      sampledQ <= 1'b0;
    end else if (!sampledQ) begin
      strapQ   <= strapEn;
      sampledQ <= 1'b1;
    end
  end

  assign featEn = strapQ || swEn;
  assign txReq  = txBusy || !fifoEmpty;

  always_comb begin
    stateNxt = state;
    cmd      = '0;
    if (!featEn) begin
      stateNxt = DIR_IDLE;
    end else begin
      unique case (state)
        DIR_IDLE:   if (txReq) stateNxt = DIR_ACTIVE;
        DIR_ACTIVE: if (!txReq) begin
          if (delayCfg == '0) begin
            stateNxt = DIR_IDLE;
          end else begin
            stateNxt = DIR_HOLD;
            cmd.load = 1'b1;
          end
        end
        DIR_HOLD: begin
          if (txReq) begin
            stateNxt = DIR_ACTIVE;
          end else begin
            cmd.run = 1'b1;
            if (done) stateNxt = DIR_IDLE;
          end
        end
        default: stateNxt = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= DIR_IDLE;
    else        state <= stateNxt;
  end

  assign dirOn = (state != DIR_IDLE);

  // R2
  busy_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (featEn && txReq) |=> dirOn);
  // R7
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !featEn |=> !dirOn);
  // R5
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (featEn && state == DIR_ACTIVE && !txReq && delayCfg == '0) |=> !dirOn);
  // R6
  hold_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (featEn && state == DIR_HOLD && txReq) |=> (state == DIR_ACTIVE));
endmodule

// File: rtl/rs485_dir_ctl.sv
module rs485_dir_ctl
  import rs485_dir_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strapEn,
  input  logic             swEn,
  input  logic             pinSel,
  input  logic [DLY_W-1:0] delayCfg,
  input  logic             baudTick,
  input  logic             txBusy,
  input  logic             fifoEmpty,
  output logic             rtsOut,
  output logic             dtrOut,
  output logic             txIntSel
);
  dlyCmd_t dlyCmd;
  logic    dlyDone, dirOn, featEn;

  rs485_dir_fsm #(.DLY_W(DLY_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .strapEn(strapEn), .swEn(swEn),
    .delayCfg(delayCfg), .txBusy(txBusy), .fifoEmpty(fifoEmpty),
    .done(dlyDone), .cmd(dlyCmd), .dirOn(dirOn), .featEn(featEn)
  );

  rs485_dir_delay #(.OVS(OVS), .DLY_W(DLY_W)) delay_i (
    .clk(clk), .rst_n(rst_n), .cmd(dlyCmd), .baudTick(baudTick),
    .delayCfg(delayCfg), .done(dlyDone)
  );

  assign rtsOut   = dirOn && !pinSel;
  assign dtrOut   = dirOn &&  pinSel;
  assign txIntSel = featEn;

  // R8
  pins_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rtsOut && dtrOut));
endmodule

// File: tb/rs485_dir_ctl_tb.sv
module rs485_dir_ctl_tb_top;
  localparam int OVS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strapEn = 1'b0, swEn = 1'b0, pinSel = 1'b0;
  logic [3:0] delayCfg = '0;
  logic baudTick = 1'b1, txBusy = 1'b0, fifoEmpty = 1'b1;
  logic rtsOut, dtrOut, txIntSel;
  logic sparseTick = 1'b0;
  int   nChk = 0, nBad = 0;

  always #2 clk = ~clk;

  rs485_dir_ctl #(.OVS(OVS), .DLY_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .strapEn(strapEn), .swEn(swEn),
    .pinSel(pinSel), .delayCfg(delayCfg), .baudTick(baudTick),
    .txBusy(txBusy), .fifoEmpty(fifoEmpty), .rtsOut(rtsOut),
    .dtrOut(dtrOut), .txIntSel(txIntSel)
  );

  always @(negedge clk) begin
    if (sparseTick) baudTick <= ~baudTick;
    else            baudTick <= 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic selPin();
    return pinSel ? dtrOut : rtsOut;
  endfunction

  function automatic logic otherPin();
    return pinSel ? rtsOut : dtrOut;
  endfunction

  task automatic doReset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; strapEn = strap;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    strapEn = ~strap;
  endtask

  task automatic startFrame(input int busyCycles, input logic enabled, input string req);
    fifoEmpty = 1'b0;
    @(negedge clk);
    check(req, int'(selPin()), int'(enabled));
    fifoEmpty = 1'b1; txBusy = 1'b1;
    for (int i = 0; i < busyCycles; i++) begin
      @(negedge clk);
      check(req, int'(selPin()), int'(enabled));
      check("R8", int'(otherPin()), 0);
    end
  endtask

  task automatic measure(output int hi);
    txBusy = 1'b0;
    hi = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!selPin()) break;
      hi++;
    end
  endtask

  task automatic sweep(input string src);
    int hi;
    for (int p = 0; p < 2; p++) begin
      pinSel = p[0];
      for (int n = 0; n < 16; n++) begin
        delayCfg = n[3:0];
        startFrame(3, 1'b1, "R2");
        measure(hi);
        check((n == 0) ? "R5" : "R3", hi, n * OVS);
        check({"R1 ", src}, int'(txIntSel), 1);
      end
    end
  endtask

  initial begin
    int hi;
    doReset(1'b0);
    check("R7", int'(rtsOut) + int'(dtrOut), 0);
    check("R1", int'(txIntSel), 0);

    startFrame(4, 1'b0, "R7");
    txBusy = 1'b0;
    @(negedge clk);
    check("R7", int'(rtsOut) + int'(dtrOut), 0);

    swEn = 1'b1;
    @(negedge clk);
    sweep("sw");

    // R4: FIFO empty but shifting for a long time keeps the line driven
    pinSel = 1'b0; delayCfg = 4'd2;
    startFrame(100, 1'b1, "R4");
    measure(hi);
    check("R4", hi, 2 * OVS);

    // R6: new data during the turnaround, then a full recount
    delayCfg = 4'd8;
    startFrame(2, 1'b1, "R6");
    txBusy = 1'b0;
    repeat (10) @(negedge clk);
    check("R6", int'(selPin()), 1);
    fifoEmpty = 1'b0;
    @(negedge clk);
    fifoEmpty = 1'b1; txBusy = 1'b1;
    repeat (40) begin
      @(negedge clk);
      check("R6", int'(selPin()), 1);
    end
    measure(hi);
    check("R6", hi, 8 * OVS);

    // R3: gated ticks, one tick every other cycle
    sparseTick = 1'b1;
    delayCfg = 4'd5;
    startFrame(3, 1'b1, "R2");
    measure(hi);
    nChk++;
    if (hi < 2 * 5 * OVS - 1 || hi > 2 * 5 * OVS) begin
      nBad++;
      $display("FAIL R3 actual=%0d expected=%0d", hi, 2 * 5 * OVS);
    end
    sparseTick = 1'b0;

    // R1: enable through the strap alone; later strap changes are ignored
    swEn = 1'b0;
    @(negedge clk);
    check("R1", int'(txIntSel), 0);
    doReset(1'b1);
    check("R1", int'(txIntSel), 1);
    sweep("strap");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule